// File: doc/BRIEF.md
# Buffered Asynchronous Frame Transmitter

This block turns characters handed over on a simple write port into asynchronous serial frames on one output line. A one-entry holding buffer sits in front of a parallel-in, serial-out shifter. The shifter can therefore send one character while the next one waits in the buffer, and the two frames leave with no idle time between them. Bit timing comes from an external oversample enable: every serial bit lasts sixteen of its pulses. The block has no baud divider of its own.

The frame format is chosen at run time by three inputs: a character-size code, a parity code and a stop-count select. These settings are taken into the frame when the buffer hands a character to the shifter. Software polls a buffer-empty flag to know when it may write again. It polls a transmit-complete flag to know when the line has gone quiet. Each flag has a matching interrupt output gated by its own enable input.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line output is 1, buffer-empty is 1 and transmit-complete is 0.
- R2: A frame is a 0 start bit, then the data bits least significant first, then the optional parity bit, then stop bits at 1. Each bit lasts exactly 16 pulses of `tick`. The line rests at 1 between frames.
- R3: `size_code` selects the number of data bits: 000=5, 001=6, 010=7, 011=8, 111=9. Written bits above the selected size are not sent. The ninth bit is taken from `wr_bit8` in the same cycle as the write.
- R4: `par_code` 10 appends even parity, equal to the XOR of the data bits sent. 11 appends odd parity, the inverse of that XOR. 00 sends no parity bit.
- R5: The reserved size codes 100, 101 and 110 behave as 8 data bits. The reserved parity code 01 behaves as no parity.
- R6: `two_stop` = 0 sends one stop bit and `two_stop` = 1 sends two.
- R7: A buffered character moves into the shifter in the cycle after the write when the shifter is idle. Otherwise it moves at the end of the last stop bit, so the next start bit follows at once with no idle bit.
- R8: `buf_empty` is 0 exactly while a character waits in the buffer. A write while the buffer holds a character is dropped.
- R9: `tx_done` rises at the end of a last stop bit when no character is waiting. It stays set until a `done_ack` pulse clears it.
- R10: While `tx_en` is 0, writes are dropped. A frame already on the line and a character already in the buffer are still sent in full.
- R11: `empty_irq` equals `buf_empty` AND `empty_ie`. `done_irq` equals `tx_done` AND `done_ie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversample enable, 16 per serial bit |
| tx_en | input | 1 | Transmitter enable; gates new writes |
| size_code | input | 3 | Character size code |
| par_code | input | 2 | Parity mode code |
| two_stop | input | 1 | 1 selects two stop bits |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Low eight data bits of the character |
| wr_bit8 | input | 1 | Ninth data bit for 9-bit characters |
| done_ack | input | 1 | Interrupt acknowledge; clears transmit-complete |
| empty_ie | input | 1 | Buffer-empty interrupt enable |
| done_ie | input | 1 | Transmit-complete interrupt enable |
| txd | output | 1 | Registered serial line output |
| buf_empty | output | 1 | Holding buffer has no character waiting |
| tx_done | output | 1 | Transmit-complete flag |
| empty_irq | output | 1 | Buffer-empty interrupt |
| done_irq | output | 1 | Transmit-complete interrupt |

## Verification
The hardest case to reach from the ports is the handoff in the single cycle where a last stop bit ends while the buffer is full. Here the shifter must reload at once, `tx_done` must stay low, and `buf_empty` must rise. The stimulus reaches this state by writing a second character during the first frame's start bit. It then samples the line one bit time after the middle of the first frame's last stop bit, where a 0 is required. The same frame pair is used to show that a third write while full is dropped, and that dropping `tx_en` with a character still buffered does not cut the pair short.

// File: rtl/uft_pkg.sv
package uft_pkg;

  // longest frame: start + 9 data + parity + 2 stop
  localparam int FRAME_W = 13;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [2:0] size;
    logic [1:0] par;
    logic       two_stop;
  } frame_cfg_t;

  // number of data bits selected by the size code; reserved codes give 8
  function automatic int data_len(input logic [2:0] code);
    case (code)
      3'b000:  return 5;
      3'b001:  return 6;
      3'b010:  return 7;
      3'b011:  return 8;
      3'b111:  return 9;
      default: return 8;
    endcase
  endfunction

  // only the two defined parity codes (1x) insert a parity bit
  function automatic logic parity_on(input logic [1:0] code);
    return code[1];
  endfunction

  function automatic logic parity_of(input logic [8:0] d, input int n, input logic odd);
    logic x;
    x = 1'b0;
    for (int i = 0; i < 9; i++) begin
      if (i < n) x = x ^ d[i];
    end
    return x ^ odd;
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input frame_cfg_t c);
    int total;
    total = 1 + data_len(c.size) + (parity_on(c.par) ? 1 : 0) + (c.two_stop ? 2 : 1);
    return LEN_W'(total);
  endfunction

  // frame image, bit 0 goes on the line first; unused upper bits are mark
  function automatic logic [FRAME_W-1:0] build_frame(input logic [8:0] d, input frame_cfg_t c);
    logic [FRAME_W-1:0] f;
    int n;
    f    = '1;
    f[0] = 1'b0;
    n    = data_len(c.size);
    for (int i = 0; i < 9; i++) begin
      if (i < n) f[i+1] = d[i];
    end
    if (parity_on(c.par)) f[n+1] = parity_of(d, n, c.par[0]);
    return f;
  endfunction

endpackage

// File: rtl/uft_hold_buf.sv
module uft_hold_buf #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] word
);

  logic accept;
  assign accept = wr_en & tx_en & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else begin
      if (accept) begin
        full <= 1'b1;
        word <= wr_word;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

  // R8
  held_word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> $stable(word));

  // R8
  full_until_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> full);

endmodule

// File: rtl/uft_shifter.sv
module uft_shifter
  import uft_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [8:0] word,
  input  frame_cfg_t cfg,
  output logic       txd,
  output logic       busy,
  output logic       frame_end
);

  localparam int CNT_W = (OSR > 1) ? $clog2(OSR) : 1;

  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   left;
  logic [CNT_W-1:0]   tcnt;
  logic               bit_end;

  assign bit_end   = busy & tick & (tcnt == CNT_W'(OSR - 1));
  assign frame_end = bit_end & (left == LEN_W'(1));
  assign txd       = shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      left  <= '0;
      tcnt  <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      shreg <= build_frame(word, cfg);
      left  <= frame_len(cfg);
      tcnt  <= '0;
      busy  <= 1'b1;
    end else if (bit_end) begin
      shreg <= {1'b1, shreg[FRAME_W-1:1]};
      left  <= left - LEN_W'(1);
      tcnt  <= '0;
      if (left == LEN_W'(1)) busy <= 1'b0;
    end else if (busy && tick) begin
      tcnt <= tcnt + CNT_W'(1);
    end
  end

  // R2
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  // R2
  start_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);

  // R7
  reload_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && busy) |-> frame_end);

endmodule

// File: rtl/uft_flags.sv
module uft_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic full,
  input  logic ack,
  input  logic empty_ie,
  input  logic done_ie,
  output logic tx_done,
  output logic empty_irq,
  output logic done_irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_done <= 1'b0;
    else if (frame_end && !full) tx_done <= 1'b1;
    else if (ack) tx_done <= 1'b0;
  end

  assign empty_irq = ~full & empty_ie;
  assign done_irq  = tx_done & done_ie;

  // R9
  done_rise_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $past(frame_end));

  // R9
  done_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !ack) |=> tx_done);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uft_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       tx_en,
  input  logic [2:0] size_code,
  input  logic [1:0] par_code,
  input  logic       two_stop,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wr_bit8,
  input  logic       done_ack,
  input  logic       empty_ie,
  input  logic       done_ie,
  output logic       txd,
  output logic       buf_empty,
  output logic       tx_done,
  output logic       empty_irq,
  output logic       done_irq
);

  logic       full;
  logic [8:0] held;
  logic       busy;
  logic       frame_end;
  logic       load;
  frame_cfg_t cfg;

  assign cfg       = '{size: size_code, par: par_code, two_stop: two_stop};
  assign load      = full & (~busy | frame_end);
  assign buf_empty = ~full;

  uft_hold_buf #(.DATA_W(9)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .wr_en   (wr_en),
    .wr_word ({wr_bit8, wr_data}),
    .take    (load),
    .full    (full),
    .word    (held)
  );

  uft_shifter #(.OSR(OSR)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load      (load),
    .word      (held),
    .cfg       (cfg),
    .txd       (txd),
    .busy      (busy),
    .frame_end (frame_end)
  );

  uft_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .full      (full),
    .ack       (done_ack),
    .empty_ie  (empty_ie),
    .done_ie   (done_ie),
    .tx_done   (tx_done),
    .empty_irq (empty_irq),
    .done_irq  (done_irq)
  );

  // R10
  fill_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(tx_en));

  // R7
  load_from_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> full);

endmodule

// File: tb/uart_frame_tx_bench.sv
`timescale 1ns/1ps
module uart_frame_tx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       tx_en = 1'b0;
  logic [2:0] size_code = 3'b011;
  logic [1:0] par_code = 2'b00;
  logic       two_stop = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_bit8 = 1'b0;
  logic       done_ack = 1'b0;
  logic       empty_ie = 1'b0;
  logic       done_ie = 1'b0;
  logic       txd, buf_empty, tx_done, empty_irq, done_irq;

  int checks = 0;
  int errors = 0;
  int tp = 1;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  uart_frame_tx u_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en),
    .size_code(size_code), .par_code(par_code), .two_stop(two_stop),
    .wr_en(wr_en), .wr_data(wr_data), .wr_bit8(wr_bit8),
    .done_ack(done_ack), .empty_ie(empty_ie), .done_ie(done_ie),
    .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done),
    .empty_irq(empty_irq), .done_irq(done_irq)
  );

  // oversample enable: one pulse every tp cycles
  initial begin
    int div;
    div = 0;
    forever begin
      @(negedge clk);
      if (div >= tp - 1) begin tick = 1'b1; div = 0; end
      else begin tick = 1'b0; div = div + 1; end
    end
  end

  // {size(3), parity(2), two_stop(1), data(9)}
  localparam logic [14:0] VEC [8] = '{
    {3'b000, 2'b00, 1'b0, 9'h1F5},
    {3'b001, 2'b10, 1'b0, 9'h0AB},
    {3'b010, 2'b11, 1'b0, 9'h07F},
    {3'b011, 2'b00, 1'b1, 9'h0C3},
    {3'b111, 2'b11, 1'b0, 9'h155},
    {3'b101, 2'b10, 1'b0, 9'h1E6},
    {3'b011, 2'b01, 1'b1, 9'h05A},
    {3'b111, 2'b10, 1'b1, 9'h1FF}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int b_nbits(input logic [2:0] s);
    if (s == 3'b111) return 9;
    if (s[2]) return 8;
    return 5 + int'(s[1:0]);
  endfunction

  function automatic logic [15:0] b_frame(input logic [2:0] s, input logic [1:0] p,
                                          input logic two, input logic [8:0] d, output int len);
    int n;
    logic [8:0] m;
    logic pb;
    bit pon;
    logic [15:0] v;
    n   = b_nbits(s);
    m   = 9'h1FF >> (9 - n);
    pon = (p == 2'b10) || (p == 2'b11);
    pb  = ^(d & m);
    if (p == 2'b11) pb = ~pb;
    v = (16'hFFFF << (n + 1)) | (16'(d & m) << 1);
    if (pon) v[n+1] = pb;
    len = 1 + n + (pon ? 1 : 0) + (two ? 2 : 1);
    return v;
  endfunction

  task automatic put(input logic [7:0] d, input logic b8);
    @(negedge clk);
    wr_data = d; wr_bit8 = b8; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ack_done();
    @(negedge clk); done_ack = 1'b1;
    @(negedge clk); done_ack = 1'b0;
  endtask

  // entered at the middle of a start bit, leaves at the middle of the last bit
  task automatic recv_body(input int len, output logic [15:0] got);
    got = '1;
    for (int i = 0; i < len; i++) begin
      got[i] = txd;
      if (i != len - 1) repeat (16 * tp) @(negedge clk);
    end
  endtask

  task automatic recv_frame(input int len, output logic [15:0] got);
    int w;
    w = 0;
    got = '1;
    while (txd !== 1'b0 && w < 5000) begin @(negedge clk); w++; end
    if (w >= 5000) begin
      chk(1'b0, "R2", "start bit timeout", 1, 0);
    end else begin
      repeat (8 * tp) @(negedge clk);
      recv_body(len, got);
    end
  endtask

  function automatic logic [15:0] lmask(input int len);
    return (16'h1 << len) - 16'h1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] got, exp, expb;
    int len, lenb, lows;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
    chk(buf_empty == 1'b1, "R1", "buf_empty after reset", buf_empty, 1);
    chk(tx_done == 1'b0, "R1", "tx_done after reset", tx_done, 0);

    tx_en = 1'b1;
    // table walk: R2 R3 R4 R5 R6 frame shapes
    for (int k = 0; k < 8; k++) begin
      logic [14:0] v;
      v = VEC[k];
      @(negedge clk);
      size_code = v[14:12]; par_code = v[11:10]; two_stop = v[9];
      ack_done();
      exp = b_frame(v[14:12], v[11:10], v[9], v[8:0], len);
      put(v[7:0], v[8]);
      recv_frame(len, got);
      chk((got & lmask(len)) == (exp & lmask(len)), "R2 R3 R4 R5 R6", "frame bits",
          int'(got & lmask(len)), int'(exp & lmask(len)));
      // R9: not yet complete in the middle of the last stop bit
      chk(tx_done == 1'b0, "R9", "tx_done during last stop", tx_done, 0);
      repeat (16 * tp) @(negedge clk);
      chk(txd == 1'b1, "R2", "line idle after frame", txd, 1);
      chk(tx_done == 1'b1, "R9", "tx_done after frame", tx_done, 1);
    end

    // R9 flag holds until acknowledged
    repeat (20) @(negedge clk);
    chk(tx_done == 1'b1, "R9", "tx_done held", tx_done, 1);
    done_ie = 1'b1;
    @(negedge clk);
    chk(done_irq == 1'b1, "R11", "done_irq enabled", done_irq, 1);
    done_ie = 1'b0;
    @(negedge clk);
    chk(done_irq == 1'b0, "R11", "done_irq masked", done_irq, 0);
    ack_done();
    chk(tx_done == 1'b0, "R9", "tx_done after ack", tx_done, 0);
    empty_ie = 1'b1;
    @(negedge clk);
    chk(empty_irq == 1'b1, "R11", "empty_irq enabled", empty_irq, 1);
    empty_ie = 1'b0;
    @(negedge clk);
    chk(empty_irq == 1'b0, "R11", "empty_irq masked", empty_irq, 0);

    // R7 R8 back-to-back frames, write while full dropped
    size_code = 3'b011; par_code = 2'b00; two_stop = 1'b0;
    exp  = b_frame(3'b011, 2'b00, 1'b0, 9'h03C, len);
    expb = b_frame(3'b011, 2'b00, 1'b0, 9'h0A5, lenb);
    put(8'h3C, 1'b0);
    put(8'hA5, 1'b0);
    chk(buf_empty == 1'b0, "R8", "buf_empty with char waiting", buf_empty, 0);
    put(8'hFF, 1'b0);
    recv_frame(len, got);
    chk((got & lmask(len)) == (exp & lmask(len)), "R7", "first frame", int'(got), int'(exp & lmask(len)));
    chk(buf_empty == 1'b0, "R8", "buffer still waiting at last stop", buf_empty, 0);
    repeat (16) @(negedge clk);
    chk(txd == 1'b0, "R7", "no gap before second start", txd, 0);
    chk(buf_empty == 1'b1, "R8", "buffer empty after handoff", buf_empty, 1);
    chk(tx_done == 1'b0, "R9", "no completion at busy handoff", tx_done, 0);
    recv_body(lenb, got);
    chk((got & lmask(lenb)) == (expb & lmask(lenb)), "R7", "second frame", int'(got), int'(expb & lmask(lenb)));
    lows = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
    chk(lows == 0, "R8", "dropped write not sent", lows, 0);
    ack_done();

    // R10 disable lets buffered data finish, drops new writes
    put(8'h81, 1'b0);
    put(8'h42, 1'b0);
    @(negedge clk);
    tx_en = 1'b0;
    exp  = b_frame(3'b011, 2'b00, 1'b0, 9'h081, len);
    expb = b_frame(3'b011, 2'b00, 1'b0, 9'h042, lenb);
    recv_frame(len, got);
    chk((got & lmask(len)) == (exp & lmask(len)), "R10", "in-flight frame", int'(got), int'(exp & lmask(len)));
    repeat (16) @(negedge clk);
    recv_body(lenb, got);
    chk((got & lmask(lenb)) == (expb & lmask(lenb)), "R10", "buffered frame", int'(got), int'(expb & lmask(lenb)));
    repeat (16) @(negedge clk);
    put(8'h00, 1'b0);
    chk(buf_empty == 1'b1, "R10", "write while disabled", buf_empty, 1);
    lows = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
    chk(lows == 0, "R10", "no frame while disabled", lows, 0);

    // R2 slower oversample enable
    tx_en = 1'b1;
    tp = 3;
    repeat (10) @(negedge clk);
    size_code = 3'b010; par_code = 2'b10; two_stop = 1'b1;
    exp = b_frame(3'b010, 2'b10, 1'b1, 9'h05B, len);
    put(8'h5B, 1'b0);
    recv_frame(len, got);
    chk((got & lmask(len)) == (exp & lmask(len)), "R2", "frame at slow tick", int'(got), int'(exp & lmask(len)));

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule